// File: doc/BRIEF.md
# Linked Dual-Compare PWM Timer

This block is a small timer with one free-running up-counter and two compare channels, A and B. The counter climbs from zero to a programmable modulo value and returns to zero on the following cycle. That return is the period start. Each channel drives its own output pin. At a compare match the pin is forced to a programmable level. At each period start the pin can be restored to the opposite level. Together these produce edge-aligned PWM with a duty cycle anywhere from 0% to 100%.

Channel A's mode field can select buffered operation. The two compare registers then serve as a pair of pulse-width sources for pin A, and software writes the idle one while the other is driving the pin. The register written last takes over at the next period start, so a new width never cuts into a period that is already running. While the channels are linked, channel B's control register has no effect, pin B is held low, and a status output tells the surrounding logic that pin B may be used as general-purpose I/O.

All configuration goes through a single-cycle write port. A stop input freezes the counter. A clear input restarts the period from zero.

Top module: `bpwm_timer`

## Requirements
- R1: The counter steps up by one per cycle while running and goes to 0 in the cycle after it equals the modulo value, so a period lasts modulo+1 cycles; reset leaves both pins low and the free flag low.
- R2: While the stop input is high the counter holds its value. The clear input loads 0 and starts a new period whether or not the counter is stopped.
- R3: Write addresses are 0 modulo, 1 compare A, 2 compare B, 3 control A and 4 control B. Control bits are [0] overflow restore, [2:1] edge/level and [4:3] mode.
- R4: Take edge/level 10, overflow restore 1 and compare value C with 1 <= C <= modulo. The pin is then high exactly while the count is below C, which gives C high cycles per period.
- R5: Edge/level 11 inverts the polarity. The pin is low while the count is below C and high for the remaining modulo+1-C cycles.
- R6: C = 0 keeps the pin at the compare level for the whole period, because the compare action wins over the restore at the period start. C above the modulo value never matches, so the pin stays at the restore level for the whole period.
- R7: In unbuffered mode (mode 01) the two channels run independently from their own compare registers, and a compare write takes effect within the current period.
- R8: Mode 10 on channel A links the channels. Pin B is then held low, the free flag is high, and writes to control B do not change pin B.
- R9: Right after linking, compare A is the active width. A write to the inactive compare register does not change the current period and takes effect from the next period start.
- R10: At each period start of a linked pair, the active source becomes the compare register written last. A write to the active register changes the current period, just as in unbuffered mode.
- R11: Mode 00 disables a channel, and its pin then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| cnt_stop_i | input | 1 | Counter hold |
| cnt_clear_i | input | 1 | Counter restart to zero |
| pwm_a_o | output | 1 | Channel A pin (buffered PWM when linked) |
| pwm_b_o | output | 1 | Channel B pin |
| b_pin_free_o | output | 1 | Pin B released for general-purpose use |
| count_o | output | 16 | Current counter value |

## Verification
The assertions rely on at most one register write per cycle. They also assume that a compare write never lands in a cycle that is itself a period start, because a write there would count toward the period after next. The stimulus only writes at count values 1 to 4 of periods that are at least eight cycles long, and it drives clear and stop at falling edges. After every modulo change the bench pulses clear, so the counter never runs past a lowered modulo value.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

  localparam int ADDR_W = 3;
  localparam int CTL_W  = 5;

  localparam logic [ADDR_W-1:0] ADDR_MOD  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP0 = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL0 = 3'd3;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_BUF = 2'b10;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] edge_lvl;
    logic       ovf_restore;
  } ctl_t;

  function automatic logic chan_enabled(input ctl_t c);
    return c.mode != MODE_OFF;
  endfunction

endpackage

// File: rtl/bpwm_rst_sync.sv
module bpwm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/bpwm_regs.sv
module bpwm_regs
  import bpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CHAN = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  output logic [CNT_W-1:0]              mod_o,
  output logic [N_CHAN-1:0][CNT_W-1:0]  cmp_o,
  output ctl_t [N_CHAN-1:0]             ctl_o,
  output logic [N_CHAN-1:0]             wr_cmp_o
);
  logic [CNT_W-1:0] mod_q, mod_d;

  always_comb begin
    mod_d = mod_q;
    if (wr_en_i && wr_addr_i == ADDR_MOD) mod_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mod_q <= '1;
    else         mod_q <= mod_d;
  end

  assign mod_o = mod_q;

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan_regs
    localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_CMP0 + ADDR_W'(g);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_CTL0 + ADDR_W'(g);

    logic [CNT_W-1:0] cmp_q, cmp_d;
    ctl_t             ctl_q, ctl_d;
    logic             cmp_hit, ctl_hit;

    always_comb begin
      cmp_hit = wr_en_i && (wr_addr_i == CMP_ADDR);
      ctl_hit = wr_en_i && (wr_addr_i == CTL_ADDR);
      cmp_d   = cmp_hit ? wr_data_i : cmp_q;
      ctl_d   = ctl_hit ? ctl_t'(wr_data_i[CTL_W-1:0]) : ctl_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q <= '0;
        ctl_q <= '0;
      end else begin
        cmp_q <= cmp_d;
        ctl_q <= ctl_d;
      end
    end

    assign cmp_o[g]    = cmp_q;
    assign ctl_o[g]    = ctl_q;
    assign wr_cmp_o[g] = cmp_hit;
  end
endmodule

// File: rtl/bpwm_counter.sv
module bpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             start_o,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run, at_mod;

  always_comb begin
    run    = !stop_i;
    at_mod = (cnt_q == mod_i);
    if (clear_i)     cnt_d = '0;
    else if (!run)   cnt_d = cnt_q;
    else if (at_mod) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;
  assign start_o    = clear_i || (run && at_mod);
  assign run_o      = run;

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !stop_i && cnt_q == mod_i) |=> (cnt_q == '0));
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !stop_i && cnt_q != mod_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && stop_i) |=> $stable(cnt_q));
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/bpwm_link.sv
module bpwm_link #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             linked_i,
  input  logic             start_i,
  input  logic [1:0]       wr_cmp_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  output logic [CNT_W-1:0] cmp_eff_o
);
  logic linked_q;
  logic last_b_q, last_b_d;
  logic sel_b_q, sel_b_d;
  logic link_set, cur_b;

  always_comb begin
    link_set = linked_i && !linked_q;

    last_b_d = last_b_q;
    if (link_set)                     last_b_d = 1'b0;
    else if (linked_i && wr_cmp_i[1]) last_b_d = 1'b1;
    else if (linked_i && wr_cmp_i[0]) last_b_d = 1'b0;

    sel_b_d = sel_b_q;
    if (link_set)                 sel_b_d = 1'b0;
    else if (linked_i && start_i) sel_b_d = last_b_q;

    if (link_set)     cur_b = 1'b0;
    else if (start_i) cur_b = last_b_q;
    else              cur_b = sel_b_q;

    cmp_eff_o = (linked_i && cur_b) ? cmp_b_i : cmp_a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      linked_q <= 1'b0;
      last_b_q <= 1'b0;
      sel_b_q  <= 1'b0;
    end else begin
      linked_q <= linked_i;
      last_b_q <= last_b_d;
      sel_b_q  <= sel_b_d;
    end
  end

  a_r9_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !link_set) |=> $stable(sel_b_q));
  a_r10_take_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (linked_i && start_i && !link_set) |=> (sel_b_q == $past(last_b_q)));
  a_r9_link_starts_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_set |=> (!sel_b_q && !last_b_q));
endmodule

// File: rtl/bpwm_chan.sv
module bpwm_chan
  import bpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  ctl_t             ctl_i,
  output logic             pin_o
);
  logic out_q, out_d;
  logic hit;

  always_comb begin
    hit   = ctl_i.edge_lvl[1] && (cnt_next_i == cmp_i);
    out_d = out_q;
    if (!en_i)                             out_d = 1'b0;
    else if ((run_i || start_i) && hit)    out_d = ctl_i.edge_lvl[0];
    else if (start_i && ctl_i.ovf_restore) out_d = !ctl_i.edge_lvl[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign pin_o = out_q;

  a_r11_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pin_o);
  a_r2_frozen_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run_i && !start_i) |=> $stable(pin_o));
endmodule

// File: rtl/bpwm_timer.sv
module bpwm_timer
  import bpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              cnt_stop_i,
  input  logic              cnt_clear_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic              b_pin_free_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int N_CHAN = 2;

  logic                         rst_n;
  logic [CNT_W-1:0]             mod;
  logic [N_CHAN-1:0][CNT_W-1:0] cmp;
  ctl_t [N_CHAN-1:0]            ctl;
  logic [N_CHAN-1:0]            wr_cmp;
  logic [CNT_W-1:0]             cnt, cnt_next, cmp_eff_a;
  logic                         start, run, linked;
  logic [N_CHAN-1:0]            en;
  logic [N_CHAN-1:0][CNT_W-1:0] cmp_use;
  logic [N_CHAN-1:0]            pin;

  bpwm_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  bpwm_regs #(.CNT_W(CNT_W), .N_CHAN(N_CHAN)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .mod_o(mod), .cmp_o(cmp), .ctl_o(ctl), .wr_cmp_o(wr_cmp)
  );

  bpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .stop_i(cnt_stop_i), .clear_i(cnt_clear_i),
    .mod_i(mod), .cnt_o(cnt), .cnt_next_o(cnt_next), .start_o(start), .run_o(run)
  );

  assign linked = (ctl[0].mode == MODE_BUF);

  bpwm_link #(.CNT_W(CNT_W)) u_link (
    .clk_i(clk_i), .rst_ni(rst_n), .linked_i(linked), .start_i(start),
    .wr_cmp_i(wr_cmp), .cmp_a_i(cmp[0]), .cmp_b_i(cmp[1]), .cmp_eff_o(cmp_eff_a)
  );

  always_comb begin
    en[0]      = chan_enabled(ctl[0]);
    en[1]      = chan_enabled(ctl[1]) && !linked;
    cmp_use[0] = cmp_eff_a;
    cmp_use[1] = cmp[1];
  end

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    bpwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i(clk_i), .rst_ni(rst_n), .en_i(en[g]), .run_i(run), .start_i(start),
      .cnt_next_i(cnt_next), .cmp_i(cmp_use[g]), .ctl_i(ctl[g]), .pin_o(pin[g])
    );
  end

  assign pwm_a_o      = pin[0];
  assign pwm_b_o      = pin[1];
  assign b_pin_free_o = linked;
  assign count_o      = cnt;

  a_r8_b_released: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(linked) && linked) |-> (!pwm_b_o && b_pin_free_o));
endmodule

// File: tb/tb_bpwm_timer.sv
module tb_bpwm_timer;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        stop, clr;
  logic        pwm_a_o, pwm_b_o, b_pin_free_o;
  logic [15:0] count_o;

  int n_chk = 0;
  int n_fail = 0;
  int mod_val;

  always #10 clk = !clk;

  bpwm_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cnt_stop_i(stop), .cnt_clear_i(clr),
    .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .b_pin_free_o(b_pin_free_o), .count_o(count_o)
  );

  function automatic logic [15:0] ctl(input logic [1:0] m, input logic [1:0] e, input logic t);
    return {11'b0, m, e, t};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_mod(input int m);
    wr(3'd0, 16'(m));
    mod_val = m;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic measure(input bit do_wr, input logic [2:0] a, input logic [15:0] d,
                         input int at, output int ha, output int hb);
    bit done_wr;
    ha = 0; hb = 0; done_wr = 1'b0;
    @(negedge clk);
    while (count_o != 16'd0) @(negedge clk);
    for (int i = 0; i <= mod_val; i++) begin
      ha += int'(pwm_a_o);
      hb += int'(pwm_b_o);
      if (do_wr && !done_wr && count_o == 16'(at)) begin
        wr_en = 1'b1; wr_addr = a; wr_data = d; done_wr = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ha, hb, e, c1, per;
    rst_ni = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; stop = 1'b0; clr = 1'b0;
    mod_val = 65535;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 reset pin A", int'(pwm_a_o), 0);
    chk("R1 reset pin B", int'(pwm_b_o), 0);
    chk("R1 reset free flag", int'(b_pin_free_o), 0);

    // R1 and R3: period of modulo+1, wrap to 0
    set_mod(7);
    while (count_o != 16'd7) @(negedge clk);
    @(negedge clk);
    chk("R1 wrap to zero", int'(count_o), 0);
    @(negedge clk);
    chk("R1 step", int'(count_o), 1);

    // R2: stop holds, clear restarts while stopped
    @(negedge clk); stop = 1'b1;
    @(negedge clk); c1 = int'(count_o);
    repeat (3) @(negedge clk);
    chk("R2 stop holds", int'(count_o), c1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R2 clear while stopped", int'(count_o), 0);
    stop = 1'b0; @(negedge clk);
    chk("R2 resume", int'(count_o), 1);

    // R4 R5 R6 R7: sweep compare on both channels, opposite polarities
    wr(3'd3, ctl(2'b01, 2'b10, 1'b1));
    wr(3'd4, ctl(2'b01, 2'b11, 1'b1));
    per = mod_val + 1;
    for (int c = 0; c <= mod_val + 2; c++) begin
      wr(3'd1, 16'(c));
      wr(3'd2, 16'(c));
      measure(1'b0, 3'd0, 16'd0, 0, ha, hb);
      measure(1'b0, 3'd0, 16'd0, 0, ha, hb);
      e = (c == 0) ? 0 : ((c > mod_val) ? per : c);
      chk($sformatf("R4 R6 R7 pin A high cycles C=%0d", c), ha, e);
      chk($sformatf("R5 R6 R7 pin B high cycles C=%0d", c), hb, per - e);
    end

    // R7: unbuffered write takes effect within the running period
    wr(3'd1, 16'd5);
    measure(1'b0, 3'd0, 16'd0, 0, ha, hb);
    chk("R7 steady width", ha, 5);
    measure(1'b1, 3'd1, 16'd3, 1, ha, hb);
    chk("R7 immediate unbuffered write", ha, 3);

    // R8 R9 R10: linked pair
    set_mod(15);
    wr(3'd3, ctl(2'b10, 2'b10, 1'b1));
    wr(3'd1, 16'd4);
    measure(1'b0, 3'd0, 16'd0, 0, ha, hb);
    chk("R9 compare A active after link", ha, 4);
    chk("R8 pin B held low", hb, 0);
    chk("R8 free flag", int'(b_pin_free_o), 1);
    measure(1'b1, 3'd2, 16'd10, 2, ha, hb);
    chk("R9 inactive write leaves current period", ha, 4);
    measure(1'b0, 3'd0, 16'd0, 0, ha, hb);
    chk("R9 inactive write at next period", ha, 10);
    measure(1'b1, 3'd1, 16'd6, 2, ha, hb);
    chk("R10 B still active this period", ha, 10);
    measure(1'b0, 3'd0, 16'd0, 0, ha, hb);
    chk("R10 switch back to A", ha, 6);
    while (count_o != 16'd1) @(negedge clk);
    wr(3'd2, 16'd3);
    wr(3'd1, 16'd12);
    measure(1'b0, 3'd0, 16'd0, 0, ha, hb);
    chk("R10 last written wins", ha, 12);
    measure(1'b1, 3'd1, 16'd5, 2, ha, hb);
    chk("R10 active write acts now", ha, 5);
    wr(3'd4, ctl(2'b01, 2'b11, 1'b1));
    measure(1'b0, 3'd0, 16'd0, 0, ha, hb);
    chk("R8 control B ignored", hb, 0);

    // R11: disabled channels
    wr(3'd3, ctl(2'b00, 2'b10, 1'b1));
    wr(3'd4, ctl(2'b00, 2'b11, 1'b1));
    measure(1'b0, 3'd0, 16'd0, 0, ha, hb);
    chk("R11 pin A off", ha, 0);
    chk("R11 pin B off", hb, 0);
    chk("R11 free flag cleared", int'(b_pin_free_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule